// File: doc/BRIEF.md
# USB Link Attach and Bus-Reset Sequencer

This block sits on the link side of a UTMI+ style transceiver. It walks the transceiver through the device-attach sequence and through every bus reset that follows. It watches three inputs: the cable-power-valid flag, the two-bit line state reported by the transceiver, and a flag giving the current operating speed (full speed or high speed). From these it drives the transceiver select, the termination select and the data-plus pull-up enable. It also raises a device-reset pulse, and then a one-cycle request that starts the high-speed detection handshake. All intervals are counted in clock cycles, derived from a clock-frequency parameter, so a bench can run them short.

Time zero is the cycle in which cable power becomes valid. The sequencer moves through these states in order: DETACHED, ATTACH_WAIT (full-speed select and terminations, pull-up off), DEBOUNCE (pull-up on, line ignored), WAIT_RESET (looks for a reset), DEV_RESET (internal reset held), HS_REQ (handshake request), RESET_EXIT (waits for the end of the reset signalling), J_HOLD (full-speed exit: waits one low-speed bit time of J), and ACTIVE.

The transitions are these:
- power valid: DETACHED to ATTACH_WAIT
- attach timer expired: to DEBOUNCE
- debounce timer expired: to WAIT_RESET
- filtered SE0 in WAIT_RESET, J_HOLD or ACTIVE: to DEV_RESET
- reset timer expired: to HS_REQ
- always: HS_REQ to RESET_EXIT
- line leaves SE0 at high speed: RESET_EXIT to ACTIVE
- line leaves SE0 at full speed: RESET_EXIT to J_HOLD
- J timer expired: J_HOLD to ACTIVE
- power lost in any state: to DETACHED

Top module: `ulink_attach_seq`

## Requirements
- R1: During reset, and in DETACHED, the outputs are: `seq_phase`=0, pull-up off, `dev_reset`=0, `hs_detect_req`=0, `xcvr_sel`=01 (full speed) and `term_sel`=0. Phase codes: 0 DETACHED, 1 ATTACH_WAIT, 2 DEBOUNCE, 3 WAIT_RESET, 4 DEV_RESET, 5 HS_REQ, 6 RESET_EXIT, 7 J_HOLD, 8 ACTIVE.
- R2: The cycle after power is sampled valid, phase 1 begins, with `xcvr_sel`=01, `term_sel`=1 and the pull-up off. Phase 1 lasts ATTACH_US worth of cycles; after that the pull-up turns on and phase 2 begins.
- R3: Phase 2 lasts DEBOUNCE_US worth of cycles. Any line state during this phase, SE0 included, causes no reset. After it, phase 3 begins.
- R4: Line state is encoded 00=SE0, 01=J, 10=K, 11=SE1. SE0 counts as a reset only after SE0_MIN_CLKS consecutive samples. A shorter SE0 run has no effect.
- R5: `dev_reset` rises the cycle after the SE0 is recognised and stays high for exactly RST_CYCLES cycles.
- R6: `hs_detect_req` is high for one single cycle, in the cycle right after `dev_reset` falls.
- R7: In ACTIVE with `hs_mode`=1, the outputs are `xcvr_sel`=00 and `term_sel`=0. When a reset SE0 arrives, both return to full speed (01 and 1) SE0_MIN_CLKS+1 cycles after the SE0 starts. That delay must be below 1.25 µs.
- R8: A reset taken at full speed keeps `term_sel`=1 and `xcvr_sel`=01 throughout.
- R9: At full speed, once SE0 ends, J must be seen for one low-speed bit time (LS_BIT_NS, rounded up to whole cycles) with no break before ACTIVE is entered. Any non-J sample restarts that count.
- R10: At high speed, the end of SE0 leads to ACTIVE on the next cycle.
- R11: When power is lost, every state goes to DETACHED on the next cycle and the pull-up turns off. A later attach runs the full attach interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_valid | input | 1 | Cable power valid |
| line_state | input | 2 | Transceiver line state (00 SE0, 01 J, 10 K, 11 SE1) |
| hs_mode | input | 1 | Device currently operating at high speed |
| xcvr_sel | output | 2 | Transceiver select: 00 high speed, 01 full speed |
| term_sel | output | 1 | Termination select: 1 full speed, 0 high speed |
| dp_pullup_en | output | 1 | Data-plus pull-up enable (attach signalling) |
| dev_reset | output | 1 | Internal device reset, held RST_CYCLES cycles |
| hs_detect_req | output | 1 | One-cycle request to start the high-speed detection handshake |
| seq_phase | output | 4 | Current sequencer phase code |

## Verification
The hardest case to reach is the high-speed fallback. The sequencer must first finish attach, debounce and one complete full-speed reset exit before it is ACTIVE, and only then can `hs_mode` be raised. A fresh SE0 is then timed so the bench can confirm the selects stay at high speed for exactly SE0_MIN_CLKS cycles and drop on the next one. Two scenarios are set up with exact cycle counts from the same route. One is a J hold broken by a single K, which shows the restart. The other is an SE0 held through debounce, which shows a reset is taken on the first cycle of WAIT_RESET and not earlier.

// File: rtl/ulink_seq_pkg.sv
package ulink_seq_pkg;

    typedef enum logic [3:0] {
        PH_DETACHED    = 4'd0,
        PH_ATTACH_WAIT = 4'd1,
        PH_DEBOUNCE    = 4'd2,
        PH_WAIT_RESET  = 4'd3,
        PH_DEV_RESET   = 4'd4,
        PH_HS_REQ      = 4'd5,
        PH_RESET_EXIT  = 4'd6,
        PH_J_HOLD      = 4'd7,
        PH_ACTIVE      = 4'd8
    } seq_phase_e;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_e;

    localparam logic [1:0] XCVR_HS = 2'b00;
    localparam logic [1:0] XCVR_FS = 2'b01;

    // Whole cycles covering a span in microseconds (at least one).
    function automatic int cycles_from_us(input longint hz, input longint us);
        longint c;
        c = (hz * us) / 64'd1000000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    // Whole cycles covering a span in nanoseconds, rounded up (at least one).
    function automatic int cycles_from_ns_ceil(input longint hz, input longint ns);
        longint c;
        c = (hz * ns + 64'd999999999) / 64'd1000000000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/ulink_seq_timer.sv
module ulink_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != limit) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign expired = (cnt_q == limit);

    // R2: every timed phase is entered through a restart, so the count never passes its limit
    p_count_within_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q <= limit));

endmodule

// File: rtl/ulink_line_filter.sv
module ulink_line_filter
    import ulink_seq_pkg::*;
#(
    parameter int SE0_MIN_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    output logic       se0_hold
);

    localparam int CW = $clog2(SE0_MIN_CLKS + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(SE0_MIN_CLKS);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (line_state != LS_SE0) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + CW'(1);
        end
    end

    assign se0_hold = (run_q == RUN_MAX);

    // R4: a recognised SE0 always follows a sampled SE0
    p_hold_needs_se0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        se0_hold |-> ($past(line_state) == LS_SE0));

endmodule

// File: rtl/ulink_attach_seq.sv
module ulink_attach_seq
    import ulink_seq_pkg::*;
#(
    parameter int CLK_HZ       = 60_000_000,
    parameter int ATTACH_US    = 10_000,
    parameter int DEBOUNCE_US  = 100_000,
    parameter int LS_BIT_NS    = 667,
    parameter int SE0_MIN_CLKS = 16,
    parameter int RST_CYCLES   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_valid,
    input  logic [1:0] line_state,
    input  logic       hs_mode,
    output logic [1:0] xcvr_sel,
    output logic       term_sel,
    output logic       dp_pullup_en,
    output logic       dev_reset,
    output logic       hs_detect_req,
    output logic [3:0] seq_phase
);

    localparam int ATTACH_CLKS   = cycles_from_us(longint'(CLK_HZ), longint'(ATTACH_US));
    localparam int DEBOUNCE_CLKS = cycles_from_us(longint'(CLK_HZ), longint'(DEBOUNCE_US));
    localparam int LS_BIT_CLKS   = cycles_from_ns_ceil(longint'(CLK_HZ), longint'(LS_BIT_NS));
    localparam int MAX_AB        = (ATTACH_CLKS > DEBOUNCE_CLKS) ? ATTACH_CLKS : DEBOUNCE_CLKS;
    localparam int MAX_CD        = (LS_BIT_CLKS > RST_CYCLES) ? LS_BIT_CLKS : RST_CYCLES;
    localparam int MAX_CLKS      = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW            = $clog2(MAX_CLKS + 1);
    localparam int RW            = $clog2(SE0_MIN_CLKS + 2);
    localparam int PW            = $clog2(RST_CYCLES + 1);

    seq_phase_e    state_q, state_d;
    logic [TW-1:0] tmr_limit;
    logic          tmr_restart;
    logic          tmr_expired;
    logic          se0_hold;

    // ---------------- SE0 qualification ----------------
    ulink_line_filter #(
        .SE0_MIN_CLKS (SE0_MIN_CLKS)
    ) i_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_state (line_state),
        .se0_hold   (se0_hold)
    );

    // ---------------- phase timer ----------------
    always_comb begin
        unique case (state_q)
            PH_ATTACH_WAIT: tmr_limit = TW'(ATTACH_CLKS - 1);
            PH_DEBOUNCE:    tmr_limit = TW'(DEBOUNCE_CLKS - 1);
            PH_DEV_RESET:   tmr_limit = TW'(RST_CYCLES - 1);
            PH_J_HOLD:      tmr_limit = TW'(LS_BIT_CLKS - 1);
            default:        tmr_limit = '0;
        endcase
    end

    assign tmr_restart = (state_d != state_q) ||
                         ((state_q == PH_J_HOLD) && (line_state != LS_J));

    ulink_seq_timer #(
        .W (TW)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_DETACHED;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_DETACHED:    if (vbus_valid) state_d = PH_ATTACH_WAIT;
            PH_ATTACH_WAIT: if (tmr_expired) state_d = PH_DEBOUNCE;
            PH_DEBOUNCE:    if (tmr_expired) state_d = PH_WAIT_RESET;
            PH_WAIT_RESET:  if (se0_hold) state_d = PH_DEV_RESET;
            PH_DEV_RESET:   if (tmr_expired) state_d = PH_HS_REQ;
            PH_HS_REQ:      state_d = PH_RESET_EXIT;
            PH_RESET_EXIT: begin
                if (line_state != LS_SE0) begin
                    state_d = hs_mode ? PH_ACTIVE : PH_J_HOLD;
                end
            end
            PH_J_HOLD: begin
                if (se0_hold)         state_d = PH_DEV_RESET;
                else if (tmr_expired) state_d = PH_ACTIVE;
            end
            PH_ACTIVE:      if (se0_hold) state_d = PH_DEV_RESET;
            default:        state_d = PH_DETACHED;
        endcase
        if (!vbus_valid) begin
            state_d = PH_DETACHED;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        xcvr_sel      = XCVR_FS;
        term_sel      = 1'b1;
        dp_pullup_en  = 1'b1;
        dev_reset     = 1'b0;
        hs_detect_req = 1'b0;
        unique case (state_q)
            PH_DETACHED: begin
                term_sel     = 1'b0;
                dp_pullup_en = 1'b0;
            end
            PH_ATTACH_WAIT: dp_pullup_en = 1'b0;
            PH_DEBOUNCE, PH_WAIT_RESET, PH_RESET_EXIT, PH_J_HOLD: begin
            end
            PH_DEV_RESET: dev_reset = 1'b1;
            PH_HS_REQ:    hs_detect_req = 1'b1;
            PH_ACTIVE: begin
                if (hs_mode) begin
                    xcvr_sel = XCVR_HS;
                    term_sel = 1'b0;
                end
            end
            default: begin
                term_sel     = 1'b0;
                dp_pullup_en = 1'b0;
            end
        endcase
    end

    assign seq_phase = state_q;

    // ---------------- checking state ----------------
    logic [RW-1:0] se0_run_q;
    logic [PW-1:0] rst_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            se0_run_q <= '0;
            rst_run_q <= '0;
        end else begin
            if (line_state != LS_SE0)                  se0_run_q <= '0;
            else if (se0_run_q != RW'(SE0_MIN_CLKS + 1)) se0_run_q <= se0_run_q + RW'(1);
            if (!dev_reset)                            rst_run_q <= '0;
            else if (rst_run_q != PW'(RST_CYCLES))     rst_run_q <= rst_run_q + PW'(1);
        end
    end

    // R11: loss of power detaches on the next cycle
    p_power_loss_detaches_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_valid |=> (seq_phase == PH_DETACHED) && !dp_pullup_en);

    // R6: the handshake request is one cycle wide
    p_req_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_detect_req |=> !hs_detect_req);

    // R6: the handshake request follows the device reset
    p_req_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_detect_req |-> $past(dev_reset));

    // R5: the device reset never outlasts its length
    p_reset_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> (rst_run_q < PW'(RST_CYCLES)));

    // R7: an SE0 longer than the qualification window means full-speed selects
    p_hs_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (se0_run_q > RW'(SE0_MIN_CLKS)) |-> (xcvr_sel == XCVR_FS));

    // R2: the pull-up only turns on at the end of the attach wait
    p_pullup_after_attach_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp_pullup_en) |-> ($past(seq_phase) == PH_ATTACH_WAIT));

endmodule

// File: tb/test_ulink_attach_seq.sv
module test_ulink_attach_seq;

    localparam int CLK_HZ     = 200_000_000;
    localparam int ATT_US     = 2;      // 400 cycles
    localparam int DEB_US     = 5;      // 1000 cycles
    localparam int LSB_NS     = 667;    // ceil(133.4) = 134 cycles
    localparam int SE0_MIN    = 8;
    localparam int RST_LEN    = 6;
    localparam int ATT_CLKS   = 400;
    localparam int DEB_CLKS   = 1000;
    localparam int LSB_CLKS   = 134;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vbus_valid;
    logic [1:0] line_state;
    logic       hs_mode;
    logic [1:0] xcvr_sel;
    logic       term_sel;
    logic       dp_pullup_en;
    logic       dev_reset;
    logic       hs_detect_req;
    logic [3:0] seq_phase;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ulink_attach_seq #(
        .CLK_HZ       (CLK_HZ),
        .ATTACH_US    (ATT_US),
        .DEBOUNCE_US  (DEB_US),
        .LS_BIT_NS    (LSB_NS),
        .SE0_MIN_CLKS (SE0_MIN),
        .RST_CYCLES   (RST_LEN)
    ) i_ulink_attach_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .vbus_valid    (vbus_valid),
        .line_state    (line_state),
        .hs_mode       (hs_mode),
        .xcvr_sel      (xcvr_sel),
        .term_sel      (term_sel),
        .dp_pullup_en  (dp_pullup_en),
        .dev_reset     (dev_reset),
        .hs_detect_req (hs_detect_req),
        .seq_phase     (seq_phase)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state;
        rst_n = 1'b0; vbus_valid = 1'b0; line_state = 2'b01; hs_mode = 1'b0;
        cyc(3);
        check("R1 phase in reset", seq_phase, 0);
        check("R1 pullup in reset", dp_pullup_en, 0);
        check("R1 xcvr in reset", xcvr_sel, 1);
        check("R1 term in reset", term_sel, 0);
        check("R1 dev_reset in reset", dev_reset, 0);
        check("R1 req in reset", hs_detect_req, 0);
        rst_n = 1'b1;
        cyc(3);
        check("R1 stays detached without power", seq_phase, 0);
    endtask

    // Attach, debounce with SE0 held, first reset, full-speed exit
    task automatic t_attach_and_first_reset;
        vbus_valid = 1'b1;
        cyc(1);
        check("R2 attach wait entered", seq_phase, 1);
        check("R2 fs select", xcvr_sel, 1);
        check("R2 fs term", term_sel, 1);
        check("R2 pullup off early", dp_pullup_en, 0);
        cyc(ATT_CLKS - 1);
        check("R2 still attach wait", seq_phase, 1);
        check("R2 pullup still off", dp_pullup_en, 0);
        cyc(1);
        check("R2 debounce entered", seq_phase, 2);
        check("R2 pullup on", dp_pullup_en, 1);
        line_state = 2'b00;
        cyc(DEB_CLKS - 1);
        check("R3 SE0 ignored in debounce phase", seq_phase, 2);
        check("R3 SE0 ignored in debounce reset", dev_reset, 0);
        cyc(1);
        check("R3 wait reset entered", seq_phase, 3);
        cyc(1);
        check("R5 dev_reset rises", dev_reset, 1);
        check("R8 term kept fs", term_sel, 1);
        cyc(RST_LEN - 1);
        check("R5 dev_reset last cycle", dev_reset, 1);
        cyc(1);
        check("R5 dev_reset falls", dev_reset, 0);
        check("R6 req pulse", hs_detect_req, 1);
        cyc(1);
        check("R6 req single", hs_detect_req, 0);
        check("R9 reset exit waits", seq_phase, 6);
        line_state = 2'b01;
        cyc(1);
        check("R9 j hold entered", seq_phase, 7);
        cyc(LSB_CLKS - 1);
        check("R9 j hold not done", seq_phase, 7);
        cyc(1);
        check("R9 active after bit time", seq_phase, 8);
        check("R8 term fs in active", term_sel, 1);
    endtask

    // Short SE0 glitch, full-speed reset, broken J hold
    task automatic t_filter_and_j_restart;
        line_state = 2'b00;
        cyc(SE0_MIN - 1);
        line_state = 2'b01;
        cyc(10);
        check("R4 short SE0 ignored phase", seq_phase, 8);
        check("R4 short SE0 ignored reset", dev_reset, 0);
        line_state = 2'b00;
        cyc(SE0_MIN);
        check("R4 not yet recognised", seq_phase, 8);
        cyc(1);
        check("R4 recognised", seq_phase, 4);
        check("R8 fs term during reset", term_sel, 1);
        check("R8 fs select during reset", xcvr_sel, 1);
        cyc(RST_LEN - 1);
        cyc(1);
        check("R6 req after fs reset", hs_detect_req, 1);
        cyc(1);
        line_state = 2'b01;
        cyc(50);
        check("R9 holding J", seq_phase, 7);
        line_state = 2'b10;
        cyc(1);
        line_state = 2'b01;
        cyc(LSB_CLKS - 1);
        check("R9 K restarted count", seq_phase, 7);
        cyc(1);
        check("R9 active after full J", seq_phase, 8);
    endtask

    // High-speed fallback and high-speed exit
    task automatic t_hs_reset;
        hs_mode = 1'b1;
        cyc(1);
        check("R7 hs select in active", xcvr_sel, 0);
        check("R7 hs term in active", term_sel, 0);
        line_state = 2'b00;
        cyc(SE0_MIN);
        check("R7 hs select before window", xcvr_sel, 0);
        cyc(1);
        check("R7 fs select after window", xcvr_sel, 1);
        check("R7 fs term after window", term_sel, 1);
        check("R5 reset from hs", dev_reset, 1);
        cyc(RST_LEN);
        check("R6 req after hs reset", hs_detect_req, 1);
        cyc(1);
        check("R7 fs kept in exit", xcvr_sel, 1);
        line_state = 2'b01;
        cyc(1);
        check("R10 hs exit direct", seq_phase, 8);
        check("R10 hs select restored", xcvr_sel, 0);
    endtask

    // Power loss from active and during debounce
    task automatic t_power_loss;
        hs_mode = 1'b0;
        vbus_valid = 1'b0;
        cyc(1);
        check("R11 detached from active", seq_phase, 0);
        check("R11 pullup off", dp_pullup_en, 0);
        vbus_valid = 1'b1;
        cyc(200);
        vbus_valid = 1'b0;
        cyc(1);
        check("R11 detached mid attach", seq_phase, 0);
        vbus_valid = 1'b1;
        cyc(ATT_CLKS);
        check("R11 full attach again", seq_phase, 1);
        cyc(1);
        check("R11 debounce after full attach", seq_phase, 2);
        cyc(300);
        vbus_valid = 1'b0;
        cyc(1);
        check("R11 detached mid debounce", seq_phase, 0);
        check("R11 pullup off mid debounce", dp_pullup_en, 0);
    endtask

    initial begin
        t_reset_state();
        t_attach_and_first_reset();
        t_filter_and_j_restart();
        t_hs_reset();
        t_power_loss();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule